// File: doc/BRIEF.md
# Oscillator Frequency-Locked Trim Loop

This block keeps an on-chip RC oscillator on frequency by comparing it with a slow but accurate reference clock. The reference is divided by 32, which gives a 1.024 kHz measurement window when the reference runs at 32.768 kHz. The block counts oscillator cycles across each whole window and compares the count with a 16-bit target ratio. Integration ties the target to 0x7A12 for a 32 MHz oscillator, or to 0xB71B when the oscillator is retuned to 48 MHz. A count above the target means the oscillator is fast, and the fine trim code then drops by one. A count below the target means the oscillator is slow, and the fine code then rises by one. Errors that stay inside a programmable dead band leave the code unchanged.

The 13-bit trim word has two parts. The 7-bit fine code is the part the loop servoes. The 6-bit coarse code is set only by software. While the loop is disabled, software writes go directly to the trim outputs. While the loop is enabled, those writes are dropped. A sleep input stops the oscillator. While it is high the loop freezes, and on wake-up the loop continues from the code it held.

Top module: `dfll_trim`

## Requirements
- R1: After reset, `fine_o` is 64, `coarse_o` is 32 and `en_status_o` is 0.
- R2: `en_status_o` follows `en_i` one oscillator cycle later. When the loop is disabled, any partial measurement is discarded.
- R3: Measurement windows last 32 reference periods. Adjustments happen at most once per window. While the oscillator is steady, successive adjustments are spaced exactly one window apart. The first window after enable or wake-up only arms the measurement and never adjusts.
- R4: When the cycle count in a window is below the target by more than `HALF_STEP`, `fine_o` increases by exactly one.
- R5: When the cycle count in a window is above the target by more than `HALF_STEP`, `fine_o` decreases by exactly one.
- R6: When the count differs from the target by `HALF_STEP` or less (default 2), `fine_o` does not change. A difference of `HALF_STEP`+1 does cause an adjustment.
- R7: `fine_o` saturates at 127 when the oscillator is slow and at 0 when it is fast. It never wraps.
- R8: While the loop is enabled, `coarse_o` never changes, and software writes to either trim field are ignored.
- R9: While the loop is disabled, a write strobe loads its field, and the new value appears on the trim output one cycle later.
- R10: While `sleep_i` is high, `fine_o` is frozen. After wake-up, the next adjustment starts from the held value and comes only after a complete new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock being trimmed; main clock domain |
| ref_clk_i | input | 1 | Accurate reference clock (32.768 kHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Loop enable |
| sleep_i | input | 1 | Oscillator stopped by sleep; freezes the loop |
| target_i | input | 16 | Expected oscillator cycles per measurement window |
| sw_fine_we_i | input | 1 | Software write strobe for the fine field |
| sw_fine_i | input | 7 | Software fine value |
| sw_coarse_we_i | input | 1 | Software write strobe for the coarse field |
| sw_coarse_i | input | 6 | Software coarse value |
| fine_o | output | 7 | Fine trim code to the oscillator |
| coarse_o | output | 6 | Coarse trim code to the oscillator |
| en_status_o | output | 1 | Loop running status |

## Verification
If the window counter or its arming state is wrong, the error shows on `fine_o` within one or two windows. An adjustment comes in the arming window, the spacing between adjustments is not one window, or the step goes the wrong way for the chosen target. A dead-band or saturation fault shows once the target is placed exactly at the threshold or the code is preloaded next to a limit. A fault in the write gating or the sleep freeze shows on the trim outputs in the very next cycle.

// File: rtl/dfll_pkg.sv
package dfll_pkg;
  localparam int FINE_W   = 7;
  localparam int COARSE_W = 6;
  localparam int CNT_W    = 16;

  typedef enum logic [1:0] {
    CMP_HOLD = 2'd0,
    CMP_UP   = 2'd1,
    CMP_DOWN = 2'd2
  } cmp_e;
endpackage

// File: rtl/dfll_ref_div.sv
module dfll_ref_div #(
  parameter int DIV = 32
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic div_o
);
  localparam int W = $clog2(DIV);

  logic [W-1:0] cnt_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // one rising edge of the MSB every DIV reference cycles
  assign div_o = cnt_q[W-1];
endmodule

// File: rtl/dfll_edge_sync.sv
module dfll_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dfll_period_meas.sv
module dfll_period_meas
  import dfll_pkg::*;
#(
  parameter int CW        = CNT_W,
  parameter int HALF_STEP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] target_i,
  output logic          valid_o,
  output cmp_e          verdict_o
);
  localparam int XW = CW + 2;

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic [XW-1:0] meas_x, tgt_x, half_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (cnt_q != '1) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // count includes the closing tick cycle
  assign meas_x = XW'(cnt_q) + XW'(1);
  assign tgt_x  = XW'(target_i);
  assign half_x = XW'(HALF_STEP);

  always_comb begin
    if (meas_x > tgt_x + half_x)      verdict_o = CMP_DOWN;
    else if (meas_x + half_x < tgt_x) verdict_o = CMP_UP;
    else                              verdict_o = CMP_HOLD;
  end

  assign valid_o = run_i & tick_i & armed_q;

  // R3: a verdict needs a running loop in the previous cycle (arming window)
  a_r3_armed_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(run_i));

  // R2: disabling abandons the window; no verdict right after
  a_r2_abandon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !valid_o);
endmodule

// File: rtl/dfll_trim_reg.sv
module dfll_trim_reg
  import dfll_pkg::*;
#(
  parameter logic [FINE_W-1:0]   FINE_RST   = 7'd64,
  parameter logic [COARSE_W-1:0] COARSE_RST = 6'd32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                valid_i,
  input  cmp_e                verdict_i,
  input  logic                sw_fine_we_i,
  input  logic [FINE_W-1:0]   sw_fine_i,
  input  logic                sw_coarse_we_i,
  input  logic [COARSE_W-1:0] sw_coarse_i,
  output logic [FINE_W-1:0]   fine_o,
  output logic [COARSE_W-1:0] coarse_o
);
  localparam logic [FINE_W-1:0] FMAX = '1;

  logic [FINE_W-1:0]   fine_q;
  logic [COARSE_W-1:0] coarse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_q   <= FINE_RST;
      coarse_q <= COARSE_RST;
    end else if (!en_i) begin
      if (sw_fine_we_i)   fine_q   <= sw_fine_i;
      if (sw_coarse_we_i) coarse_q <= sw_coarse_i;
    end else if (valid_i) begin
      case (verdict_i)
        CMP_UP:   if (fine_q != FMAX) fine_q <= fine_q + 1'b1;
        CMP_DOWN: if (fine_q != '0)   fine_q <= fine_q - 1'b1;
        default:  ;
      endcase
    end
  end

  assign fine_o   = fine_q;
  assign coarse_o = coarse_q;

  a_r8_coarse_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(coarse_q));

  a_r8_fine_sw_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !valid_i) |=> $stable(fine_q));

  a_r4_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && verdict_i == CMP_UP && fine_q != FMAX)
      |=> fine_q == $past(fine_q) + 1'b1);

  a_r5_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && verdict_i == CMP_DOWN && fine_q != '0)
      |=> fine_q == $past(fine_q) - 1'b1);

  a_r7_no_wrap_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fine_q == FMAX) |=> fine_q != '0);

  a_r7_no_wrap_bot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fine_q == '0) |=> fine_q != FMAX);
endmodule

// File: rtl/dfll_trim.sv
module dfll_trim
  import dfll_pkg::*;
#(
  parameter int REF_DIV   = 32,
  parameter int HALF_STEP = 2
) (
  input  logic                osc_clk_i,
  input  logic                ref_clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sleep_i,
  input  logic [CNT_W-1:0]    target_i,
  input  logic                sw_fine_we_i,
  input  logic [FINE_W-1:0]   sw_fine_i,
  input  logic                sw_coarse_we_i,
  input  logic [COARSE_W-1:0] sw_coarse_i,
  output logic [FINE_W-1:0]   fine_o,
  output logic [COARSE_W-1:0] coarse_o,
  output logic                en_status_o
);
  logic ref_div, tick, run, en_q, valid;
  cmp_e verdict;

  dfll_ref_div #(.DIV(REF_DIV)) u_div (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .div_o     (ref_div)
  );

  dfll_edge_sync #(.STAGES(2)) u_sync (
    .clk_i   (osc_clk_i),
    .rst_ni  (rst_ni),
    .async_i (ref_div),
    .rise_o  (tick)
  );

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign run = en_q & ~sleep_i;

  dfll_period_meas #(.CW(CNT_W), .HALF_STEP(HALF_STEP)) u_meas (
    .clk_i     (osc_clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick),
    .target_i  (target_i),
    .valid_o   (valid),
    .verdict_o (verdict)
  );

  dfll_trim_reg u_trim (
    .clk_i          (osc_clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en_q),
    .valid_i        (valid),
    .verdict_i      (verdict),
    .sw_fine_we_i   (sw_fine_we_i),
    .sw_fine_i      (sw_fine_i),
    .sw_coarse_we_i (sw_coarse_we_i),
    .sw_coarse_i    (sw_coarse_i),
    .fine_o         (fine_o),
    .coarse_o       (coarse_o)
  );

  assign en_status_o = en_q;

  a_r10_sleep_freeze: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (sleep_i && en_q) |=> $stable(fine_o));

  a_r2_status_follow: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    en_i |=> en_status_o);
endmodule

// File: tb/dfll_trim_tb.sv
module dfll_trim_tb_top;
  logic        osc_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_ni  = 1'b0;
  logic        en_i = 1'b0, sleep_i = 1'b0;
  logic [15:0] target_i = 16'd320;
  logic        sw_fine_we_i = 1'b0, sw_coarse_we_i = 1'b0;
  logic [6:0]  sw_fine_i = '0;
  logic [5:0]  sw_coarse_i = '0;
  logic [6:0]  fine_o;
  logic [5:0]  coarse_o;
  logic        en_status_o;

  int n_chk = 0, n_fail = 0;
  localparam int WIN = 320; // 32 ref periods of 40 ns at 4 ns oscillator

  always #2 osc_clk = ~osc_clk;
  initial begin #1; forever #20 ref_clk = ~ref_clk; end

  dfll_trim dut_i (
    .osc_clk_i(osc_clk), .ref_clk_i(ref_clk), .rst_ni(rst_ni),
    .en_i(en_i), .sleep_i(sleep_i), .target_i(target_i),
    .sw_fine_we_i(sw_fine_we_i), .sw_fine_i(sw_fine_i),
    .sw_coarse_we_i(sw_coarse_we_i), .sw_coarse_i(sw_coarse_i),
    .fine_o(fine_o), .coarse_o(coarse_o), .en_status_o(en_status_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge osc_clk);
  endtask

  // waits for fine_o to move; returns cycles waited (-1 on timeout)
  task automatic wait_change(input int tmo, output int cycles);
    logic [6:0] prev = fine_o;
    cycles = -1;
    for (int i = 1; i <= tmo; i++) begin
      @(negedge osc_clk);
      if (fine_o != prev) begin cycles = i; break; end
    end
  endtask

  task automatic sw_write(input logic [6:0] f, input logic [5:0] c);
    sw_fine_i = f; sw_coarse_i = c; sw_fine_we_i = 1'b1; sw_coarse_we_i = 1'b1;
    cyc(1);
    sw_fine_we_i = 1'b0; sw_coarse_we_i = 1'b0;
  endtask

  task automatic disable_loop();
    en_i = 1'b0; cyc(3);
  endtask

  task automatic t_reset();
    check(fine_o == 7'd64, "R1 fine", fine_o, 64);
    check(coarse_o == 6'd32, "R1 coarse", coarse_o, 32);
    check(en_status_o == 1'b0, "R1 status", en_status_o, 0);
  endtask

  task automatic t_status();
    en_i = 1'b1; cyc(1);
    check(en_status_o == 1'b1, "R2 status rise", en_status_o, 1);
    en_i = 1'b0; cyc(1);
    check(en_status_o == 1'b0, "R2 status fall", en_status_o, 0);
    cyc(2);
  endtask

  task automatic t_slow();
    int c1, c2;
    logic [6:0] f0 = fine_o;
    logic [5:0] c0 = coarse_o;
    target_i = 16'd400; en_i = 1'b1;
    wait_change(3*WIN, c1);
    check(c1 >= WIN, "R3 arming window", c1, WIN);
    check(fine_o == f0 + 7'd1, "R4 step up", fine_o, f0 + 1);
    wait_change(3*WIN, c2);
    check(c2 == WIN, "R3 window spacing", c2, WIN);
    check(fine_o == f0 + 7'd2, "R4 second step", fine_o, f0 + 2);
    check(coarse_o == c0, "R8 coarse untouched", coarse_o, c0);
    disable_loop();
  endtask

  task automatic t_fast();
    int c1;
    logic [6:0] f0 = fine_o;
    target_i = 16'd250; en_i = 1'b1;
    wait_change(3*WIN, c1);
    check(fine_o == f0 - 7'd1, "R5 step down", fine_o, f0 - 1);
    disable_loop();
  endtask

  task automatic t_deadband();
    int c1;
    logic [6:0] f0 = fine_o;
    target_i = 16'd322; en_i = 1'b1; cyc(4*WIN);
    check(fine_o == f0, "R6 hold at +half", fine_o, f0);
    target_i = 16'd318; cyc(3*WIN);
    check(fine_o == f0, "R6 hold at -half", fine_o, f0);
    target_i = 16'd323;
    wait_change(3*WIN, c1);
    check(fine_o == f0 + 7'd1, "R6 adjust past half", fine_o, f0 + 1);
    target_i = 16'd317;
    wait_change(3*WIN, c1);
    check(fine_o == f0, "R6 adjust past -half", fine_o, f0);
    disable_loop();
  endtask

  task automatic t_saturate();
    int c1;
    sw_write(7'd126, 6'd32);
    target_i = 16'd400; en_i = 1'b1;
    wait_change(3*WIN, c1);
    check(fine_o == 7'd127, "R7 reach max", fine_o, 127);
    cyc(3*WIN);
    check(fine_o == 7'd127, "R7 hold max", fine_o, 127);
    disable_loop();
    sw_write(7'd1, 6'd32);
    target_i = 16'd200; en_i = 1'b1;
    wait_change(3*WIN, c1);
    check(fine_o == 7'd0, "R7 reach min", fine_o, 0);
    cyc(3*WIN);
    check(fine_o == 7'd0, "R7 hold min", fine_o, 0);
    disable_loop();
  endtask

  task automatic t_sw_block();
    logic [6:0] f0 = fine_o;
    logic [5:0] c0 = coarse_o;
    target_i = 16'd320; en_i = 1'b1; cyc(2);
    sw_write(7'd5, 6'd7); cyc(1);
    check(fine_o == f0, "R8 fine write ignored", fine_o, f0);
    check(coarse_o == c0, "R8 coarse write ignored", coarse_o, c0);
    disable_loop();
  endtask

  task automatic t_sw_write();
    sw_fine_i = 7'd90; sw_coarse_i = 6'd17;
    sw_fine_we_i = 1'b1; sw_coarse_we_i = 1'b1;
    cyc(1);
    sw_fine_we_i = 1'b0; sw_coarse_we_i = 1'b0;
    check(fine_o == 7'd90, "R9 fine direct", fine_o, 90);
    check(coarse_o == 6'd17, "R9 coarse direct", coarse_o, 17);
  endtask

  task automatic t_sleep();
    int c1;
    logic [6:0] held;
    target_i = 16'd400; en_i = 1'b1;
    wait_change(3*WIN, c1);
    cyc(5);
    sleep_i = 1'b1; held = fine_o;
    cyc(4*WIN);
    check(fine_o == held, "R10 frozen in sleep", fine_o, held);
    sleep_i = 1'b0;
    wait_change(3*WIN, c1);
    check(c1 >= WIN && c1 <= 2*WIN + 8, "R10 full window after wake", c1, WIN);
    check(fine_o == held + 7'd1, "R10 resume from held", fine_o, held + 1);
    disable_loop();
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_status();
    t_slow();
    t_fast();
    t_deadband();
    t_saturate();
    t_sw_block();
    t_sw_write();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule